// File: doc/BRIEF.md
# Planar Video Memory Graphics Controller

This block connects a byte-wide processor port to a video memory organised as several parallel bit planes that all share one address. A processor write does not store its byte directly. The byte is rotated and combined with per-plane latches through a selectable logic operation. Each bit position then chooses between that result and the latch value, and only the planes enabled in a plane enable register are written. A processor read loads every plane latch at once. It returns either one chosen plane or a color-match byte that tests all planes against a reference color.

Configuration is written through a small indexed register file. There are two index/data port pairs. The graphics pair holds rotation, logic operation, modes, plane selection, reference color, plane inclusion and bit mask. The sequencer pair holds the plane enable mask. The memory array lives outside the block. The block drives one shared plane address, one write enable per plane and the packed write data of all planes. It receives the packed read data of all planes combinationally.

Top module: `plane_gfx_ctrl`

## Requirements
- R1: Writing reg_port=0 (graphics index) or reg_port=2 (sequencer index) stores reg_wdata[3:0] as that pair's index. Writing reg_port=1 or reg_port=3 stores reg_wdata into the register the pair's index selects. Graphics indices: 2 reference color, 3 rotate/operation, 4 plane select, 5 mode, 7 plane inclusion, 8 bit mask. Sequencer index: 2 plane enable. Data written to any other index changes nothing.
- R2: After reset every register is 0 except the bit mask, which is 0xFF, and cpu_rdata is 0. The plane enable mask is therefore 0, so no plane is written until it is set.
- R3: pl_we[p] is 1 exactly when cpu_wr is 1 and bit p of the plane enable mask is 1. The written plane changes in the cycle that follows the strobe edge.
- R4: In write modes 0 and 3, cpu_wdata is rotated right by rotate/operation bits 2:0 before it is combined with the latches.
- R5: Rotate/operation bits 4:3 choose how the source is combined with the plane's latch: 0 pass, 1 AND, 2 OR, 3 XOR.
- R6: Written bit i of every plane comes from the combined result where bit mask bit i is 1, and from that plane's latch where it is 0.
- R7: Write mode 1 (mode bits 1:0 = 1) writes each enabled plane with its own latch value. The bit mask, the logic operation and cpu_wdata have no effect.
- R8: Write mode 2 gives plane p a source of all ones when cpu_wdata[p] is 1 and all zeros otherwise, without rotation. The source then goes through the logic operation and the bit mask. Write mode 3 behaves as write mode 0.
- R9: Every processor read loads all plane latches from the addressed location, in either read mode.
- R10: With mode bit 3 = 0, a read returns the plane numbered by plane select bits 1:0. cpu_rdata is valid one cycle after the read strobe and holds its value until the next read.
- R11: With mode bit 3 = 1, read bit i is 1 when every plane p whose inclusion bit is 1 has bit i equal to reference color bit p. Planes whose inclusion bit is 0 are excluded, so an all-zero inclusion mask returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register port write strobe |
| reg_port | input | 2 | 0 graphics index, 1 graphics data, 2 sequencer index, 3 sequencer data |
| reg_wdata | input | DATA_W | Register port write data |
| cpu_wr | input | 1 | Processor memory write strobe |
| cpu_rd | input | 1 | Processor memory read strobe |
| cpu_addr | input | ADDR_W | Processor memory address |
| cpu_wdata | input | DATA_W | Processor write byte |
| cpu_rdata | output | DATA_W | Registered read result |
| pl_addr | output | ADDR_W | Shared plane address |
| pl_we | output | PLANES | Per-plane write enable |
| pl_wdata | output | PLANES*DATA_W | Packed plane write data, plane p at bits p*DATA_W upward |
| pl_rdata | input | PLANES*DATA_W | Packed plane read data, combinational from pl_addr |

## Verification
Write mode 0 is swept over every rotate count and every logic operation. Each combination uses several bit masks and plane enable masks, and the latches hold distinct per-plane patterns. A wrong rotation direction, a swapped operation code or an inverted mask bit therefore shows up as a mismatch in a specific plane. Write mode 2 is tried with every 4-bit color under each operation, which separates the per-plane color expansion from rotation. The color-match read is swept over all 256 pairs of reference color and inclusion mask, against planes holding orthogonal bit patterns, so each plane's contribution to the result can be told apart. Plane-select reads cover every plane at every address, and writes to unused indices are followed by a normal write that would expose any stray register change.

// File: rtl/gfx_pkg.sv
package gfx_pkg;

   // register port selector encoding
   typedef enum logic [1:0] {
      PORT_GFX_IDX  = 2'd0,
      PORT_GFX_DATA = 2'd1,
      PORT_SEQ_IDX  = 2'd2,
      PORT_SEQ_DATA = 2'd3
   } reg_port_e;

   // combine operation between source and latch
   typedef enum logic [1:0] {
      LOP_PASS = 2'd0,
      LOP_AND  = 2'd1,
      LOP_OR   = 2'd2,
      LOP_XOR  = 2'd3
   } lop_e;

   // write mode
   typedef enum logic [1:0] {
      WM_ROTATE = 2'd0,
      WM_LATCH  = 2'd1,
      WM_COLOR  = 2'd2,
      WM_ALT    = 2'd3
   } wmode_e;

   localparam int IDXW        = 4;
   localparam int MODE_RD_BIT = 3;

   localparam logic [IDXW-1:0] GIDX_REFCOLOR = 4'd2;
   localparam logic [IDXW-1:0] GIDX_ROTOP    = 4'd3;
   localparam logic [IDXW-1:0] GIDX_PLSEL    = 4'd4;
   localparam logic [IDXW-1:0] GIDX_MODE     = 4'd5;
   localparam logic [IDXW-1:0] GIDX_INCLUDE  = 4'd7;
   localparam logic [IDXW-1:0] GIDX_BITMASK  = 4'd8;
   localparam logic [IDXW-1:0] SIDX_PLANE_EN = 4'd2;

endpackage

// File: rtl/gfx_regfile.sv
module gfx_regfile
   import gfx_pkg::*;
#(
   parameter int DW      = 8,
   parameter int NPLANES = 4,
   parameter int RW      = $clog2(DW),
   parameter int SELW    = (NPLANES > 1) ? $clog2(NPLANES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_port,
   input  logic [DW-1:0]      reg_wdata,
   output logic [RW-1:0]      rot_cnt,
   output lop_e               lop,
   output wmode_e             wmode,
   output logic               rd_cmp,
   output logic [SELW-1:0]    plane_sel,
   output logic [NPLANES-1:0] ref_color,
   output logic [NPLANES-1:0] include_mask,
   output logic [DW-1:0]      bit_mask,
   output logic [NPLANES-1:0] plane_en
);

   if (DW < RW + 2 || DW <= MODE_RD_BIT || DW < IDXW) begin : g_bad_width
      $error("gfx_regfile: DW too narrow for register fields");
   end
   if (NPLANES > DW) begin : g_bad_planes
      $error("gfx_regfile: NPLANES must not exceed DW");
   end

   logic [IDXW-1:0] gfx_idx_q;
   logic [IDXW-1:0] seq_idx_q;
   reg_port_e       port;

   assign port = reg_port_e'(reg_port);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gfx_idx_q    <= '0;
         seq_idx_q    <= '0;
         rot_cnt      <= '0;
         lop          <= LOP_PASS;
         wmode        <= WM_ROTATE;
         rd_cmp       <= 1'b0;
         plane_sel    <= '0;
         ref_color    <= '0;
         include_mask <= '0;
         bit_mask     <= '1;
         plane_en     <= '0;
      end else if (reg_we) begin
         case (port)
            PORT_GFX_IDX: gfx_idx_q <= reg_wdata[IDXW-1:0];
            PORT_SEQ_IDX: seq_idx_q <= reg_wdata[IDXW-1:0];
            PORT_GFX_DATA: begin
               case (gfx_idx_q)
                  GIDX_REFCOLOR: ref_color    <= reg_wdata[NPLANES-1:0];
                  GIDX_ROTOP: begin
                     rot_cnt <= reg_wdata[RW-1:0];
                     lop     <= lop_e'(reg_wdata[RW+1:RW]);
                  end
                  GIDX_PLSEL:    plane_sel    <= reg_wdata[SELW-1:0];
                  GIDX_MODE: begin
                     wmode  <= wmode_e'(reg_wdata[1:0]);
                     rd_cmp <= reg_wdata[MODE_RD_BIT];
                  end
                  GIDX_INCLUDE:  include_mask <= reg_wdata[NPLANES-1:0];
                  GIDX_BITMASK:  bit_mask     <= reg_wdata;
                  default: ;
               endcase
            end
            PORT_SEQ_DATA: begin
               if (seq_idx_q == SIDX_PLANE_EN) plane_en <= reg_wdata[NPLANES-1:0];
            end
            default: ;
         endcase
      end
   end

   // R1: an index selects a register only through its own pair
   a_r1_idx_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_port == 2'd0) |=> $stable(bit_mask) && $stable(ref_color) && $stable(include_mask));

endmodule

// File: rtl/gfx_write_path.sv
module gfx_write_path
   import gfx_pkg::*;
#(
   parameter int DW      = 8,
   parameter int NPLANES = 4,
   parameter int RW      = $clog2(DW)
) (
   input  logic                  cpu_wr,
   input  logic [DW-1:0]         cpu_wdata,
   input  logic [RW-1:0]         rot_cnt,
   input  lop_e                  lop,
   input  wmode_e                wmode,
   input  logic [DW-1:0]         bit_mask,
   input  logic [NPLANES-1:0]    plane_en,
   input  logic [NPLANES*DW-1:0] latch_bus,
   output logic [NPLANES-1:0]    pl_we,
   output logic [NPLANES*DW-1:0] pl_wdata
);

   localparam int DBL = 2 * DW;

   logic [DBL-1:0] doubled;
   logic [DW-1:0]  rotated;

   // rotate right by shifting a doubled copy
   always_comb begin
      doubled = {cpu_wdata, cpu_wdata} >> rot_cnt;
      rotated = doubled[DW-1:0];
   end

   assign pl_we = {NPLANES{cpu_wr}} & plane_en;

   for (genvar p = 0; p < NPLANES; p++) begin : g_plane
      logic [DW-1:0] lat;
      logic [DW-1:0] src;
      logic [DW-1:0] alu;
      logic [DW-1:0] merged;
      logic [DW-1:0] plane_out;

      assign lat = latch_bus[p*DW +: DW];

      always_comb begin
         case (wmode)
            WM_COLOR: src = {DW{cpu_wdata[p]}};
            default:  src = rotated;
         endcase
         case (lop)
            LOP_AND: alu = src & lat;
            LOP_OR:  alu = src | lat;
            LOP_XOR: alu = src ^ lat;
            default: alu = src;
         endcase
         merged = (alu & bit_mask) | (lat & ~bit_mask);
         plane_out = (wmode == WM_LATCH) ? lat : merged;
      end

      assign pl_wdata[p*DW +: DW] = plane_out;
   end

endmodule

// File: rtl/gfx_read_path.sv
module gfx_read_path #(
   parameter int DW      = 8,
   parameter int NPLANES = 4,
   parameter int SELW    = (NPLANES > 1) ? $clog2(NPLANES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_rd,
   input  logic                  rd_cmp,
   input  logic [SELW-1:0]       plane_sel,
   input  logic [NPLANES-1:0]    ref_color,
   input  logic [NPLANES-1:0]    include_mask,
   input  logic [NPLANES*DW-1:0] pl_rdata,
   output logic [NPLANES*DW-1:0] latch_bus,
   output logic [DW-1:0]         cpu_rdata
);

   logic [DW-1:0] match_vec;
   logic [DW-1:0] sel_data;

   // per-bit color match across included planes
   always_comb begin
      for (int i = 0; i < DW; i++) begin
         match_vec[i] = 1'b1;
         for (int p = 0; p < NPLANES; p++) begin
            if (include_mask[p] && (pl_rdata[p*DW + i] != ref_color[p])) match_vec[i] = 1'b0;
         end
      end
   end

   // plane select multiplexer, out-of-range selects give zero
   always_comb begin
      sel_data = '0;
      for (int p = 0; p < NPLANES; p++) begin
         if (plane_sel == SELW'(p)) sel_data = pl_rdata[p*DW +: DW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_bus <= '0;
         cpu_rdata <= '0;
      end else if (cpu_rd) begin
         latch_bus <= pl_rdata;
         cpu_rdata <= rd_cmp ? match_vec : sel_data;
      end
   end

   // R10: read result holds between reads
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata));

   // R11: nothing included means every bit matches
   a_r11_none_included: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && rd_cmp && include_mask == '0) |=> cpu_rdata == '1);

endmodule

// File: rtl/plane_gfx_ctrl.sv
module plane_gfx_ctrl
   import gfx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PLANES = 4,
   parameter int ADDR_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [1:0]               reg_port,
   input  logic [DATA_W-1:0]        reg_wdata,
   input  logic                     cpu_wr,
   input  logic                     cpu_rd,
   input  logic [ADDR_W-1:0]        cpu_addr,
   input  logic [DATA_W-1:0]        cpu_wdata,
   output logic [DATA_W-1:0]        cpu_rdata,
   output logic [ADDR_W-1:0]        pl_addr,
   output logic [PLANES-1:0]        pl_we,
   output logic [PLANES*DATA_W-1:0] pl_wdata,
   input  logic [PLANES*DATA_W-1:0] pl_rdata
);

   localparam int RW   = $clog2(DATA_W);
   localparam int SELW = (PLANES > 1) ? $clog2(PLANES) : 1;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_dw
      $error("plane_gfx_ctrl: DATA_W must be a power of two of at least 8");
   end
   if (PLANES < 1 || PLANES > DATA_W) begin : g_bad_np
      $error("plane_gfx_ctrl: PLANES must lie in 1..DATA_W");
   end
   if (ADDR_W < 1) begin : g_bad_aw
      $error("plane_gfx_ctrl: ADDR_W must be positive");
   end

   logic [RW-1:0]            rot_cnt;
   lop_e                     lop;
   wmode_e                   wmode;
   logic                     rd_cmp;
   logic [SELW-1:0]          plane_sel;
   logic [PLANES-1:0]        ref_color;
   logic [PLANES-1:0]        include_mask;
   logic [DATA_W-1:0]        bit_mask;
   logic [PLANES-1:0]        plane_en;
   logic [PLANES*DATA_W-1:0] latch_bus;
   logic                     unused_hi;

   assign pl_addr   = cpu_addr;
   assign unused_hi = ^reg_wdata[DATA_W-1:RW+2];

   gfx_regfile #(
      .DW(DATA_W), .NPLANES(PLANES), .RW(RW), .SELW(SELW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_port(reg_port),
      .reg_wdata(reg_wdata), .rot_cnt(rot_cnt), .lop(lop), .wmode(wmode),
      .rd_cmp(rd_cmp), .plane_sel(plane_sel), .ref_color(ref_color),
      .include_mask(include_mask), .bit_mask(bit_mask), .plane_en(plane_en)
   );

   gfx_write_path #(
      .DW(DATA_W), .NPLANES(PLANES), .RW(RW)
   ) u_wr (
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rot_cnt(rot_cnt), .lop(lop),
      .wmode(wmode), .bit_mask(bit_mask), .plane_en(plane_en),
      .latch_bus(latch_bus), .pl_we(pl_we), .pl_wdata(pl_wdata)
   );

   gfx_read_path #(
      .DW(DATA_W), .NPLANES(PLANES), .SELW(SELW)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .rd_cmp(rd_cmp),
      .plane_sel(plane_sel), .ref_color(ref_color), .include_mask(include_mask),
      .pl_rdata(pl_rdata), .latch_bus(latch_bus), .cpu_rdata(cpu_rdata)
   );

   // R3: write enables only on a write strobe and only for enabled planes
   a_r3_we_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ((pl_we & ~plane_en) == '0) && (cpu_wr || (pl_we == '0)));

   // R7: latch-copy mode drives the latches onto every plane
   a_r7_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wmode == WM_LATCH) |-> pl_wdata == latch_bus);

   // R9: any read captures all planes into the latches
   a_r9_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> latch_bus == $past(pl_rdata));

   for (genvar p = 0; p < PLANES; p++) begin : g_chk
      // R6: masked-off bit positions keep the latch value
      a_r6_masked_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_wr |-> ((pl_wdata[p*DATA_W +: DATA_W] ^ latch_bus[p*DATA_W +: DATA_W]) & ~bit_mask) == '0);
   end

endmodule

// File: tb/tb_plane_gfx_ctrl.sv
`timescale 1ns/1ps
module tb_plane_gfx_ctrl;

   localparam int DW = 8;
   localparam int NP = 4;
   localparam int AW = 4;
   localparam int DEPTH = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_we = 1'b0;
   logic [1:0]     reg_port = '0;
   logic [DW-1:0]  reg_wdata = '0;
   logic           cpu_wr = 1'b0;
   logic           cpu_rd = 1'b0;
   logic [AW-1:0]  cpu_addr = '0;
   logic [DW-1:0]  cpu_wdata = '0;
   logic [DW-1:0]  cpu_rdata;
   logic [AW-1:0]  pl_addr;
   logic [NP-1:0]  pl_we;
   logic [NP*DW-1:0] pl_wdata;
   logic [NP*DW-1:0] pl_rdata;

   logic [7:0] mem [NP][DEPTH];
   logic [7:0] lat [NP];
   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   plane_gfx_ctrl #(.DATA_W(DW), .PLANES(NP), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_port(reg_port),
      .reg_wdata(reg_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .pl_addr(pl_addr), .pl_we(pl_we), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata)
   );

   for (genvar p = 0; p < NP; p++) begin : g_mem
      assign pl_rdata[p*8 +: 8] = mem[p][pl_addr];
   end

   always @(posedge clk) begin
      for (int p = 0; p < NP; p++) if (pl_we[p]) mem[p][pl_addr] <= pl_wdata[p*8 +: 8];
   end

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic regw(input logic [1:0] port, input logic [7:0] v);
      reg_port = port; reg_wdata = v; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic gset(input logic [3:0] idx, input logic [7:0] v);
      regw(2'd0, {4'd0, idx});
      regw(2'd1, v);
   endtask

   task automatic sset(input logic [3:0] idx, input logic [7:0] v);
      regw(2'd2, {4'd0, idx});
      regw(2'd3, v);
   endtask

   task automatic cfg(input int rot, input int op, input int wm, input int rm,
                      input logic [7:0] bm, input logic [3:0] mm);
      gset(4'd3, 8'((op << 3) | rot));
      gset(4'd5, 8'((rm << 3) | wm));
      gset(4'd8, bm);
      sset(4'd2, {4'd0, mm});
   endtask

   task automatic rd(input int addr, output logic [7:0] v);
      cpu_addr = AW'(addr);
      for (int p = 0; p < NP; p++) lat[p] = mem[p][addr];
      cpu_rd = 1'b1;
      tick();
      cpu_rd = 1'b0;
      v = cpu_rdata;
   endtask

   task automatic wr(input int addr, input logic [7:0] d);
      cpu_addr = AW'(addr); cpu_wdata = d; cpu_wr = 1'b1;
      tick();
      cpu_wr = 1'b0;
   endtask

   function automatic logic [7:0] expw(input int p, input logic [7:0] d, input logic [7:0] l,
                                       input int rot, input int op, input int wm,
                                       input logic [7:0] bm);
      logic [7:0] s, a;
      if (wm == 1) return l;
      if (wm == 2) s = d[p] ? 8'hFF : 8'h00;
      else for (int i = 0; i < 8; i++) s[i] = d[(i + rot) % 8];
      case (op)
         0: a = s;
         1: a = s & l;
         2: a = s | l;
         default: a = s ^ l;
      endcase
      return (a & bm) | (l & ~bm);
   endfunction

   function automatic logic [7:0] expcmp(input int addr, input logic [3:0] cc, input logic [3:0] dc);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         r[i] = 1'b1;
         for (int p = 0; p < NP; p++)
            if (dc[p] && (mem[p][addr][i] != cc[p])) r[i] = 1'b0;
      end
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, d, bm;
      logic [7:0] old [NP];
      logic [3:0] mm;
      int a;

      for (int p = 0; p < NP; p++)
         for (int j = 0; j < DEPTH; j++) mem[p][j] = 8'(j * 37 + p * 91 + 5);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset read result and disabled planes
      check("R2 rdata after reset", cpu_rdata, 8'h00);
      for (int p = 0; p < NP; p++) old[p] = mem[p][0];
      wr(0, 8'h55);
      for (int p = 0; p < NP; p++) check("R2 R3 plane enable resets to 0", mem[p][0], old[p]);
      // R2: bit mask resets to all ones, rotate/op/mode to zero
      sset(4'd2, 8'h0F);
      wr(1, 8'h96);
      for (int p = 0; p < NP; p++) check("R2 bit mask resets to FF", mem[p][1], 8'h96);
      mem[0][2] = 8'h3C;
      rd(2, v);
      check("R2 R10 plane select resets to 0", v, 8'h3C);

      // R3 R4 R5 R6: write mode 0 sweep
      for (int rot = 0; rot < 8; rot++) begin
         for (int op = 0; op < 4; op++) begin
            for (int bi = 0; bi < 3; bi++) begin
               bm = (bi == 0) ? 8'hFF : (bi == 1) ? 8'h5A : 8'(8'h0F ^ (rot << 4));
               mm = 4'((rot * 3 + op * 5 + bi) % 16);
               a = (rot * 4 + op + bi) % DEPTH;
               for (int p = 0; p < NP; p++) mem[p][a] = 8'(a * 53 + p * 67 + rot * 11 + op);
               cfg(rot, op, 0, 0, bm, mm);
               rd(a, v);
               check("R10 plane 0 read", v, mem[0][a]);
               d = 8'(rot * 29 + op * 71 + bi * 13 + 1);
               wr(a, d);
               for (int p = 0; p < NP; p++)
                  check(mm[p] ? "R4 R5 R6 mode0 write" : "R3 disabled plane kept",
                        mem[p][a], mm[p] ? expw(p, d, lat[p], rot, op, 0, bm) : lat[p]);
            end
         end
      end

      // R8: write mode 3 acts as mode 0
      for (int p = 0; p < NP; p++) mem[p][6] = 8'(p * 45 + 17);
      cfg(3, 2, 3, 0, 8'hE7, 4'hF);
      rd(6, v);
      wr(6, 8'hB4);
      for (int p = 0; p < NP; p++) check("R8 mode3 as mode0", mem[p][6], expw(p, 8'hB4, lat[p], 3, 2, 0, 8'hE7));

      // R8: write mode 2 color sweep
      for (int c = 0; c < 16; c++) begin
         for (int op = 0; op < 4; op++) begin
            a = (c + op) % DEPTH;
            for (int p = 0; p < NP; p++) mem[p][a] = 8'(c * 19 + p * 83 + op * 7);
            cfg(5, op, 2, 0, 8'hC3, 4'hF);
            rd(a, v);
            d = 8'(c | 8'hA0);
            wr(a, d);
            for (int p = 0; p < NP; p++) check("R8 mode2 color write", mem[p][a], expw(p, d, lat[p], 5, op, 2, 8'hC3));
         end
      end

      // R7: latch copy ignores mask, op and data
      cfg(2, 3, 1, 0, 8'h3C, 4'hF);
      rd(11, v);
      wr(12, 8'h77);
      for (int p = 0; p < NP; p++) check("R7 latch copy", mem[p][12], lat[p]);

      // R10: plane select sweep
      cfg(0, 0, 0, 0, 8'hFF, 4'hF);
      for (int s = 0; s < NP; s++) begin
         gset(4'd4, 8'(s));
         for (int j = 0; j < DEPTH; j++) begin
            rd(j, v);
            check("R10 plane select read", v, mem[s][j]);
         end
      end
      // R10: hold between reads
      gset(4'd4, 8'd1);
      rd(4, v);
      mem[1][4] = ~v;
      repeat (3) tick();
      check("R10 rdata held", cpu_rdata, v);

      // R11: color match sweep
      mem[0][5] = 8'hF0; mem[1][5] = 8'hCC; mem[2][5] = 8'hAA; mem[3][5] = 8'h0F;
      gset(4'd5, 8'h08);
      for (int cc = 0; cc < 16; cc++) begin
         for (int dc = 0; dc < 16; dc++) begin
            gset(4'd2, 8'(cc));
            gset(4'd7, 8'(dc));
            rd(5, v);
            check("R11 color match read", v, expcmp(5, 4'(cc), 4'(dc)));
         end
      end

      // R9: latches load during a color-match read
      for (int p = 0; p < NP; p++) mem[p][9] = 8'(p * 29 + 101);
      rd(9, v);
      gset(4'd5, 8'h01);
      wr(10, 8'h00);
      for (int p = 0; p < NP; p++) check("R9 latch loaded in compare mode", mem[p][10], mem[p][9]);

      // R1: writes to unused indices change nothing
      cfg(0, 0, 0, 0, 8'hFF, 4'hF);
      gset(4'd4, 8'd2);
      gset(4'd0, 8'hFF); gset(4'd1, 8'hFF); gset(4'd6, 8'hFF);
      for (int k = 9; k < 16; k++) gset(4'(k), 8'hFF);
      sset(4'd0, 8'h00); sset(4'd1, 8'h00);
      for (int k = 3; k < 16; k++) sset(4'(k), 8'h00);
      rd(13, v);
      check("R1 plane select unchanged", v, mem[2][13]);
      wr(13, 8'h69);
      for (int p = 0; p < NP; p++) check("R1 unused index ignored", mem[p][13], 8'h69);
      // R1: index uses only the low 4 bits
      regw(2'd0, 8'h38);
      regw(2'd1, 8'h0F);
      rd(14, v);
      wr(14, 8'hFF);
      for (int p = 0; p < NP; p++) check("R1 index low nibble", mem[p][14], (8'hFF & 8'h0F) | (lat[p] & 8'hF0));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule